// File: doc/BRIEF.md
# Output Fault Latch and Discharge Supervisor

This block watches two switching-regulator outputs and decides, every clock, whether each channel may switch, whether its internal discharge switch is closed, and whether its low-side gate is forced on. Analog comparators outside the block report, per output, three levels: above 111% of nominal, below 70% of nominal, and below 0.3 V. A die over-temperature flag, a protection-disable input, the global run input, the per-channel enables, a power-on-reset pulse and a 1 ms tick complete the inputs.

Three kinds of fault latch are kept. The per-channel overvoltage latches and the shared undervoltage latch arm only while protection is enabled. The thermal latch arms at all times. All of them are sticky. They clear only on the power-on-reset pulse, or on a change of level on the run input or on either channel enable. Each change is found by comparing the input with its value registered one clock earlier.

Each channel runs a three-state machine: IDLE, RUN and DRAIN. IDLE goes to RUN when the channel is wanted. RUN goes to DRAIN when the channel is no longer wanted and protection is active. RUN goes straight to IDLE on a thermal fault, an overvoltage fault or disabled protection. DRAIN goes to IDLE when the output is below 0.3 V, or on the same stop conditions. DRAIN goes back to RUN if the channel is wanted again. Once both channels are IDLE with protection active and no thermal fault, the low-side gates clamp both outputs. An overvoltage fault forces that clamp at once.

Top module: `fault_supervisor`

## Requirements
- R1: During and after reset, with prot_dis high, all latches and all of sw_en, dis_en and lsd_force are 0.
- R2: Channel i (bit 0 is channel A, bit 1 is channel B) asserts sw_en[i] when run_en and chan_en[i] are high and no fault latch is set.
- R3: With prot_dis low, ov_flag[i] high at a clock edge sets ov_lat[i] at that edge. While any ov_lat bit is set, lsd_force is 2'b11 (unless ot_lat or prot_dis), and all switching stops one clock later.
- R4: uv_lat sets only after uv_flag[i] is high while channel i switches and prot_dis is low, for 22 consecutive ms_tick pulses. It sets at the edge carrying the 22nd tick. Any clock with the condition false restarts the count.
- R5: Once uv_lat is set, both channels stop switching, and every channel that was running asserts dis_en.
- R6: dis_en[i] falls once low_flag[i] is seen. When both channels are idle, prot_dis is low and ot_lat is clear, lsd_force is 2'b11.
- R7: With prot_dis high, no overvoltage or undervoltage latch sets. A channel that turns off neither discharges nor forces its low-side gate.
- R8: hot high sets ot_lat regardless of prot_dis. While ot_lat holds, sw_en, dis_en and lsd_force are all 0.
- R9: Latches stay set after their flags fall. They clear on a por pulse or on any change of run_en or chan_en. Inputs held steady never clear them.
- R10: When a clear and a set fall on the same clock edge, the clear wins. A flag still present sets the latch again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por | input | 1 | Power-on-reset pulse, clears all fault latches |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| prot_dis | input | 1 | High disables overvoltage/undervoltage protection and discharge |
| run_en | input | 1 | Global run (low means shutdown) |
| chan_en | input | 2 | Per-channel enable |
| ov_flag | input | 2 | Output above 111% of nominal |
| uv_flag | input | 2 | Output below 70% of nominal |
| low_flag | input | 2 | Output below 0.3 V |
| hot | input | 1 | Die over-temperature |
| ov_lat | output | 2 | Overvoltage latch per channel |
| uv_lat | output | 1 | Undervoltage latch |
| ot_lat | output | 1 | Thermal latch |
| sw_en | output | 2 | Channel switching enable |
| dis_en | output | 2 | Discharge switch enable |
| lsd_force | output | 2 | Low-side gate forced on |

## Verification
A latch clear and a latch set can land on the same clock edge, for example when an overvoltage flag rises at the edge where a channel enable toggles. The bench provokes this directly by raising ov_flag and flipping chan_en together. It expects ov_lat to stay clear at that edge and to set on the next one. Random phases also mix enable flips, por pulses and overvoltage flags freely. In those phases a bench model of latch, clear and edge detection predicts ov_lat at every clock.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_t;
endpackage

// File: rtl/fsup_edge.sv
`timescale 1ns/1ps
module fsup_edge #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por,
    input  logic [NSRC-1:0] src,
    output logic            clr
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chg
        assign chg[g] = src[g] ^ prev_q[g];
    end

    assign clr = por | (|chg);

    // R9: a source held for two edges never produces a clear by itself
    a_r9_steady_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!por && src == prev_q) |-> !clr);
endmodule

// File: rtl/fsup_blank_timer.sv
`timescale 1ns/1ps
module fsup_blank_timer #(
    parameter int BLANK_MS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cond,
    input  logic ms_tick,
    output logic hit
);
    localparam int CW = $clog2(BLANK_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_MS - 1);

    logic [CW-1:0] cnt_q;

    assign hit = cond && ms_tick && !clr && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !cond) begin
            cnt_q <= '0;
        end else if (ms_tick) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> cnt_q == '0);
endmodule

// File: rtl/fsup_fault_latch.sv
`timescale 1ns/1ps
module fsup_fault_latch #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           prot_dis,
    input  logic [NCH-1:0] ov_flag,
    input  logic [NCH-1:0] uv_hit,
    input  logic           hot,
    output logic [NCH-1:0] ov_lat,
    output logic           uv_lat,
    output logic           ot_lat
);
    logic [NCH-1:0] ov_set;
    assign ov_set = ov_flag & {NCH{~prot_dis}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_lat <= '0;
            uv_lat <= 1'b0;
            ot_lat <= 1'b0;
        end else if (clr) begin
            ov_lat <= '0;
            uv_lat <= 1'b0;
            ot_lat <= 1'b0;
        end else begin
            ov_lat <= ov_lat | ov_set;
            uv_lat <= uv_lat | ((|uv_hit) & ~prot_dis);
            ot_lat <= ot_lat | hot;
        end
    end

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ov_lat == '0 && !uv_lat && !ot_lat));
    a_r9_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((ov_lat & $past(ov_lat)) == $past(ov_lat)));
    a_r8_ot_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && !clr) |=> ot_lat);
    a_r7_no_ov_when_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_dis && ov_lat == '0) |=> ov_lat == '0);
    a_r3_ov_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_dis && !clr && |ov_flag) |=> |ov_lat);
endmodule

// File: rtl/fsup_channel.sv
`timescale 1ns/1ps
module fsup_channel
    import fsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_on,
    input  logic stop,
    input  logic low_flag,
    output logic sw_en,
    output logic dis_en,
    output logic idle
);
    ch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (want_on) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (!want_on) state_d = stop ? CH_IDLE : CH_DRAIN;
            end
            CH_DRAIN: begin
                if (want_on)              state_d = CH_RUN;
                else if (stop || low_flag) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        sw_en  = (state_q == CH_RUN);
        dis_en = (state_q == CH_DRAIN);
        idle   = (state_q == CH_IDLE);
    end

    a_r5_drain_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && !want_on && !stop) |=> dis_en);
    a_r6_drain_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DRAIN && low_flag && !want_on) |=> idle);
endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
module fault_supervisor #(
    parameter int NCH      = 2,
    parameter int BLANK_MS = 22
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           por,
    input  logic           ms_tick,
    input  logic           prot_dis,
    input  logic           run_en,
    input  logic [NCH-1:0] chan_en,
    input  logic [NCH-1:0] ov_flag,
    input  logic [NCH-1:0] uv_flag,
    input  logic [NCH-1:0] low_flag,
    input  logic           hot,
    output logic [NCH-1:0] ov_lat,
    output logic           uv_lat,
    output logic           ot_lat,
    output logic [NCH-1:0] sw_en,
    output logic [NCH-1:0] dis_en,
    output logic [NCH-1:0] lsd_force
);
    localparam int NSRC = NCH + 1;

    logic           clr;
    logic [NCH-1:0] uv_hit;
    logic [NCH-1:0] want_on;
    logic [NCH-1:0] ch_dis;
    logic [NCH-1:0] ch_idle;
    logic           stop;
    logic           guard;

    fsup_edge #(.NSRC(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .por   (por),
        .src   ({chan_en, run_en}),
        .clr   (clr)
    );

    fsup_fault_latch #(.NCH(NCH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .prot_dis (prot_dis),
        .ov_flag  (ov_flag),
        .uv_hit   (uv_hit),
        .hot      (hot),
        .ov_lat   (ov_lat),
        .uv_lat   (uv_lat),
        .ot_lat   (ot_lat)
    );

    assign stop  = ot_lat | prot_dis | (|ov_lat);
    assign guard = ~ot_lat & ~prot_dis;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign want_on[c] = run_en & chan_en[c] & ~uv_lat & ~ot_lat & ~(|ov_lat);

        fsup_blank_timer #(.BLANK_MS(BLANK_MS)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .cond    (uv_flag[c] & sw_en[c] & ~prot_dis),
            .ms_tick (ms_tick),
            .hit     (uv_hit[c])
        );

        fsup_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .want_on  (want_on[c]),
            .stop     (stop),
            .low_flag (low_flag[c]),
            .sw_en    (sw_en[c]),
            .dis_en   (ch_dis[c]),
            .idle     (ch_idle[c])
        );

        assign dis_en[c]    = ch_dis[c] & guard;
        assign lsd_force[c] = guard & ((|ov_lat) | (&ch_idle));
    end

    a_r8_ot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ot_lat) && ot_lat) |-> (sw_en == '0 && dis_en == '0 && lsd_force == '0));
    a_r3_ov_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (|ov_lat && guard) |-> (&lsd_force));
    a_r5_uv_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(uv_lat) && uv_lat) |-> sw_en == '0);
    a_r7_no_discharge_dis: assert property (@(posedge clk) disable iff (!rst_n)
        prot_dis |-> (dis_en == '0 && lsd_force == '0));
endmodule

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0, ms_tick = 1'b0, prot_dis = 1'b1, run_en = 1'b0, hot = 1'b0;
    logic [1:0] chan_en = 2'b00, ov_flag = 2'b00, uv_flag = 2'b00, low_flag = 2'b00;
    logic [1:0] ov_lat, sw_en, dis_en, lsd_force;
    logic       uv_lat, ot_lat;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    fault_supervisor dut (
        .clk(clk), .rst_n(rst_n), .por(por), .ms_tick(ms_tick), .prot_dis(prot_dis),
        .run_en(run_en), .chan_en(chan_en), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .low_flag(low_flag), .hot(hot), .ov_lat(ov_lat), .uv_lat(uv_lat),
        .ot_lat(ot_lat), .sw_en(sw_en), .dis_en(dis_en), .lsd_force(lsd_force)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1; step(1);
            ms_tick = 1'b0; step(1);
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ov_model(input logic [1:0] old, input logic clr_now,
                                            input logic [1:0] ovf, input logic pd);
        if (clr_now) return 2'b00;
        return old | (ovf & {2{~pd}});
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [1:0] exp_ov, prev_en;
        logic       clr_now;
        void'($urandom(32'd4242));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 latches", {4'b0, ov_lat, uv_lat, ot_lat}, 8'h00);
        check("R1 outputs", {2'b0, sw_en, dis_en, lsd_force}, 8'h00);

        // R6 standby clamp with protection active, nothing running
        prot_dis = 1'b0; step(1);
        check("R6 standby clamp", {6'b0, lsd_force}, 8'h03);

        // R2 both channels run
        run_en = 1'b1; chan_en = 2'b11; step(3);
        check("R2 switching", {6'b0, sw_en}, 8'h03);
        check("R2 no clamp", {4'b0, dis_en, lsd_force}, 8'h00);

        // R4 blanking, restart on drop
        uv_flag = 2'b01; step(1);
        tick(21);
        check("R4 not yet 21 ticks", {7'b0, uv_lat}, 8'h00);
        uv_flag = 2'b00; step(1);
        uv_flag = 2'b01; step(1);
        tick(21);
        check("R4 restart after drop", {7'b0, uv_lat}, 8'h00);
        ms_tick = 1'b1; step(1); ms_tick = 1'b0;
        check("R4 sets on 22nd tick", {7'b0, uv_lat}, 8'h01);
        uv_flag = 2'b00;

        // R5 stop and discharge
        step(2);
        check("R5 switching off", {6'b0, sw_en}, 8'h00);
        check("R5 discharge", {6'b0, dis_en}, 8'h03);
        check("R5 no clamp yet", {6'b0, lsd_force}, 8'h00);

        // R6 discharge ends, then clamp
        low_flag = 2'b01; step(2);
        check("R6 A drained", {6'b0, dis_en}, 8'h02);
        check("R6 clamp waits", {6'b0, lsd_force}, 8'h00);
        low_flag = 2'b11; step(2);
        check("R6 B drained", {6'b0, dis_en}, 8'h00);
        check("R6 clamp both", {6'b0, lsd_force}, 8'h03);

        // R9 sticky, then clear by enable change
        step(5);
        check("R9 uv sticky", {7'b0, uv_lat}, 8'h01);
        chan_en = 2'b01; step(1);
        check("R9 cleared by toggle", {7'b0, uv_lat}, 8'h00);
        step(2);
        check("R2 A runs alone", {6'b0, sw_en}, 8'h01);

        // R3 overvoltage
        ov_flag = 2'b01; step(1); ov_flag = 2'b00;
        check("R3 ov latch", {6'b0, ov_lat}, 8'h01);
        check("R3 clamp", {6'b0, lsd_force}, 8'h03);
        step(2);
        check("R3 switching stops", {4'b0, sw_en, dis_en}, 8'h00);
        step(5);
        check("R9 ov sticky", {6'b0, ov_lat}, 8'h01);
        por = 1'b1; step(1); por = 1'b0;
        check("R9 por clears", {6'b0, ov_lat}, 8'h00);

        // R10 clear and set on the same edge
        ov_flag = 2'b10; chan_en = 2'b11; step(1);
        check("R10 clear wins", {6'b0, ov_lat}, 8'h00);
        step(1);
        check("R10 sets next edge", {6'b0, ov_lat}, 8'h02);
        ov_flag = 2'b00; por = 1'b1; step(1); por = 1'b0; step(3);
        check("R2 both again", {6'b0, sw_en}, 8'h03);

        // R7 protection disabled
        prot_dis = 1'b1;
        uv_flag = 2'b11; step(1); tick(25);
        check("R7 no uv", {7'b0, uv_lat}, 8'h00);
        ov_flag = 2'b11; step(2); ov_flag = 2'b00; uv_flag = 2'b00;
        check("R7 no ov", {6'b0, ov_lat}, 8'h00);
        low_flag = 2'b00; run_en = 1'b0; step(3);
        check("R7 off without discharge", {2'b0, sw_en, dis_en, lsd_force}, 8'h00);

        // R8 thermal
        run_en = 1'b1; step(3);
        hot = 1'b1; step(1); hot = 1'b0;
        check("R8 ot latch", {7'b0, ot_lat}, 8'h01);
        prot_dis = 1'b0; step(2);
        check("R8 all quiet", {2'b0, sw_en, dis_en, lsd_force}, 8'h00);
        step(3);
        check("R9 ot sticky", {7'b0, ot_lat}, 8'h01);
        run_en = 1'b0; step(1);
        check("R9 ot cleared", {7'b0, ot_lat}, 8'h00);

        // Random phase: R3 / R9 / R10 against bench model
        run_en = 1'b1; step(2);
        exp_ov = ov_lat;
        check("R9 random start", {6'b0, ov_lat}, 8'h00);
        prev_en = chan_en;
        for (int i = 0; i < 300; i++) begin
            por      = ($urandom % 16) == 0;
            prot_dis = $urandom % 2;
            chan_en  = chan_en ^ {($urandom % 8) == 0, ($urandom % 8) == 0};
            ov_flag  = {($urandom % 6) == 0, ($urandom % 6) == 0};
            clr_now  = por | (chan_en != prev_en);
            exp_ov   = ov_model(exp_ov, clr_now, ov_flag, prot_dis);
            prev_en  = chan_en;
            step(1);
            check("R3/R9/R10 random ov", {6'b0, ov_lat}, {6'b0, exp_ov});
        end
        summary();
    end
endmodule